// File: doc/BRIEF.md
# Threshold Offset Programming Port

This block keeps the two threshold offsets that a FIFO's flag logic compares against its fill level: one sets how close to empty the almost-empty indication begins, the other how close to full the almost-full indication begins. It has no data path of its own. Instead, it borrows the FIFO's data ports while a configuration strobe is held. A write request on the write clock then stores the low 16 bits of the input word into an offset, and a read request on the read clock copies an offset onto a read-back word.

Each side has its own selector, which alternates between the two offsets after each access: first the empty-side offset, then the full-side offset, then the empty-side offset again. A selector keeps its position while the strobe is low, so software can program one offset, return to normal FIFO traffic, and later program the other offset. Reset returns both offsets to 127 and sends both selectors back to the empty-side offset.

Top module: `flag_ofs_port`

## Requirements
- R1: After reset, both offsets equal the parameter default (127), the read-back word is zero, and the next write and the next read each address the empty-side offset.
- R2: A write-clock edge with cfg_mode=1 and wr_req=1, while the write selector points at the empty-side offset, loads din[15:0] into ae_ofs and leaves af_ofs unchanged.
- R3: The write selector alternates on every such write: the 1st, 3rd, 5th... programming writes load ae_ofs and the 2nd, 4th... load af_ofs, and one write never changes both offsets.
- R4: With cfg_mode=1 and wr_req=0, a write-clock edge changes neither offset and does not advance the write selector.
- R5: With cfg_mode=0, wr_req and rd_req have no effect on the offsets, the read-back word or either selector.
- R6: A read-clock edge with cfg_mode=1 and rd_req=1 sets rd_word to the offset that the read selector addresses, with that offset in bits 15:0 and zeros in bits 17:16. The read selector alternates empty-side then full-side.
- R7: A selector keeps its position across periods with cfg_mode=0, so programming can stop after one offset and resume with the other.
- R8: rd_word holds its value on every read-clock edge that is not a programming read.
- R9: The write and read selectors advance independently: writes do not move the read selector, and reads do not move the write selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Configuration strobe; 1 routes the data ports to the offsets |
| wr_req | input | 1 | Write request, sampled on wclk |
| rd_req | input | 1 | Read request, sampled on rclk |
| din | input | 18 | Write data; bits 15:0 carry an offset |
| ae_ofs | output | 16 | Empty-side threshold offset |
| af_ofs | output | 16 | Full-side threshold offset |
| rd_word | output | 18 | Read-back word, offset in bits 15:0 |

## Verification
On every cycle the assertions check that a programming write lands in the offset its selector addresses and only there, that offsets and the read-back word hold when no programming access happens, and that the upper read-back bits stay zero. The order of the alternation over many accesses, the survival of a selector across normal-mode traffic, and the independence of the two selectors show only in the bench scenarios, which compare against a model of the two selectors and the two offsets under random mixes of strobe, request and data.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // Selector order: empty-side, full-side, empty-side, ...
  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_pkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int WORD_W      = 18,
  parameter int OFS_DEFAULT = 127
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);

  localparam int NUM_OFS = 2;
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(OFS_DEFAULT);

  ofs_sel_e          wsel_q;
  logic              wr_fire;
  logic [OFS_W-1:0]  ofs_q [NUM_OFS];
  logic [OFS_W-1:0]  wr_val;

  assign wr_fire = cfg_mode && wr_req;
  assign wr_val  = din[OFS_W-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)       wsel_q <= SEL_EMPTY;
    else if (wr_fire) wsel_q <= next_sel(wsel_q);
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)
        ofs_q[g] <= RST_VAL;
      else if (wr_fire && (wsel_q == ofs_sel_e'(g)))
        ofs_q[g] <= wr_val;
    end
  end

  assign ae_ofs = ofs_q[SEL_EMPTY];
  assign af_ofs = ofs_q[SEL_FULL];

  // R2: a write with the selector at empty-side lands in ae_ofs only
  assert_ae_load_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wsel_q == SEL_EMPTY) |=> (ae_ofs == $past(wr_val)) && $stable(af_ofs));

  // R3: a write with the selector at full-side lands in af_ofs only
  assert_af_load_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wsel_q == SEL_FULL) |=> (af_ofs == $past(wr_val)) && $stable(ae_ofs));

  // R4, R5: no programming write, no offset change
  assert_ofs_hold_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_fire |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(wsel_q));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int WORD_W = 18
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [WORD_W-1:0] rd_word
);

  localparam int PAD_W = WORD_W - OFS_W;

  ofs_sel_e          rsel_q;
  logic              rd_fire;
  logic [OFS_W-1:0]  rd_pick;

  assign rd_fire = cfg_mode && rd_req;
  assign rd_pick = (rsel_q == SEL_EMPTY) ? ae_ofs : af_ofs;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= SEL_EMPTY;
      rd_word <= '0;
    end else if (rd_fire) begin
      rsel_q  <= next_sel(rsel_q);
      rd_word <= {{PAD_W{1'b0}}, rd_pick};
    end
  end

  // R6: read-back of the empty-side offset on the first read of a pair
  assert_rd_ae_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_fire && rsel_q == SEL_EMPTY) |=> rd_word[OFS_W-1:0] == $past(ae_ofs));

  // R6: read-back of the full-side offset on the second read of a pair
  assert_rd_af_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_fire && rsel_q == SEL_FULL) |=> rd_word[OFS_W-1:0] == $past(af_ofs));

  // R6: upper bits of the read-back word are zero
  assert_rd_pad_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_word[WORD_W-1:OFS_W] == '0);

  // R8: read-back word holds without a programming read
  assert_rd_hold_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_word) && $stable(rsel_q));

endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port #(
  parameter int OFS_W       = 16,
  parameter int WORD_W      = 18,
  parameter int OFS_DEFAULT = 127
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [WORD_W-1:0] din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic [WORD_W-1:0] rd_word
);

  ofs_wr_bank #(
    .OFS_W(OFS_W), .WORD_W(WORD_W), .OFS_DEFAULT(OFS_DEFAULT)
  ) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_req(wr_req),
    .din(din), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  ofs_rd_port #(
    .OFS_W(OFS_W), .WORD_W(WORD_W)
  ) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cfg_mode(cfg_mode), .rd_req(rd_req),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_word(rd_word)
  );

  // R1: values seen right after reset leaves
  always_ff @(posedge wclk) begin
    if (rst_n && ($past(rst_n) == 1'b0))
      assert_rst_vals_R1: assert (ae_ofs == OFS_W'(OFS_DEFAULT) || wr_req)
        else $error("ae_ofs not at default after reset");
  end

endmodule

// File: tb/test_flag_ofs_port.sv
module test_flag_ofs_port;

  logic        wclk, rclk, rst_n;
  logic        cfg_mode, wr_req, rd_req;
  logic [17:0] din;
  logic [15:0] ae_ofs, af_ofs;
  logic [17:0] rd_word;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  logic [15:0] ae_m, af_m;
  logic [17:0] rdw_m;
  bit          wsel_m, rsel_m;   // 0 = empty-side, 1 = full-side

  flag_ofs_port i_flag_ofs_port (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .wr_req(wr_req), .rd_req(rd_req), .din(din),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_word(rd_word)
  );

  initial wclk = 0;
  always #2 wclk = ~wclk;
  initial begin
    rclk = 0;
    #1;
    forever #2 rclk = ~rclk;
  end

  function automatic logic [17:0] expect_word(input logic [15:0] o);
    return {2'b00, o};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " ae_ofs"}, {2'b00, ae_ofs}, {2'b00, ae_m});
    chk({req, " af_ofs"}, {2'b00, af_ofs}, {2'b00, af_m});
    chk({req, " rd_word"}, rd_word, rdw_m);
  endtask

  task automatic wr_op(input bit c, input bit w, input logic [17:0] d);
    @(negedge wclk);
    cfg_mode = c; wr_req = w; din = d;
    @(negedge wclk);
    wr_req = 0; cfg_mode = 0;
    if (c && w) begin
      if (!wsel_m) ae_m = d[15:0];
      else         af_m = d[15:0];
      wsel_m = ~wsel_m;
    end
  endtask

  task automatic rd_op(input bit c, input bit r);
    @(negedge rclk);
    cfg_mode = c; rd_req = r;
    @(negedge rclk);
    rd_req = 0; cfg_mode = 0;
    if (c && r) begin
      rdw_m  = expect_word(rsel_m ? af_m : ae_m);
      rsel_m = ~rsel_m;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; cfg_mode = 0; wr_req = 0; rd_req = 0; din = '0;
    ae_m = 16'd127; af_m = 16'd127; rdw_m = '0; wsel_m = 0; rsel_m = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    @(negedge wclk);
    chk_all("R1 reset");

    // R1/R9: first read after reset gives empty-side default
    rd_op(1, 1);
    chk_all("R1 first read");
    rd_op(1, 1);
    chk_all("R6 second read full-side");

    // R2, R3: three writes alternate
    wr_op(1, 1, 18'h3_1234);
    chk_all("R2 first write");
    wr_op(1, 1, 18'h0_0abc);
    chk_all("R3 second write");
    wr_op(1, 1, 18'h2_fffe);
    chk_all("R3 third write");

    // R4: strobe without request
    wr_op(1, 0, 18'h1_5555);
    chk_all("R4 idle strobe");

    // R5: normal-mode traffic
    wr_op(0, 1, 18'h0_7777);
    chk_all("R5 normal write");
    rd_op(0, 1);
    chk_all("R5 normal read");

    // R7: resume programming with full-side after a pause
    wr_op(1, 1, 18'h0_4242);
    chk_all("R7 resumed write");

    // R6, R9: read selector independent of the write selector
    rd_op(1, 1);
    chk_all("R9 read empty-side");
    rd_op(1, 1);
    chk_all("R6 read full-side");
    rd_op(1, 0);
    chk_all("R8 hold");

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit c = ($urandom % 4) != 0;
      bit q = ($urandom % 3) != 0;
      if ($urandom % 2) wr_op(c, q, 18'($urandom));
      else              rd_op(c, q);
      chk_all("R3 R6 R8 random");
    end

    // R1: reset again mid-sequence
    @(negedge wclk);
    rst_n = 0;
    @(negedge wclk);
    rst_n = 1;
    ae_m = 16'd127; af_m = 16'd127; rdw_m = '0; wsel_m = 0; rsel_m = 0;
    @(negedge wclk);
    chk_all("R1 second reset");
    wr_op(1, 1, 18'h0_0011);
    chk_all("R1 selector back at empty-side");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule